// File: doc/BRIEF.md
# Line Latch with Alternating Column Polarity

This block sits between a wide display-data register and the digital-to-analog stage of a column driver. A line of 6-bit grey codes builds up in that data register. Once per horizontal period a strobe arrives. On the strobe's rising edge the whole line is copied into an output latch, and the polarity input is captured in the same edge. Neither the latch nor the captured polarity changes again until the next rising edge.

For every column the block reports four things: the latched code, a one-bit reference-bank select, a two-bit segment index that names the pair of bank references the code lies between, and a flag that marks an exact hit on the last reference of the bank. The bank select alternates between neighbouring columns, and the captured polarity decides which column gets which bank. A single drive-enable tells the analog stage when to present the levels. It rises after the strobe falls and drops at the next strobe rise. The strobe and polarity are sampled on the block clock, so every strobe edge is detected one cycle after it occurs at the pin.

Top module: `line_latch_pol`

## Requirements
- R1: In the clock cycle where the strobe is sampled high after having been sampled low, the latch loads `line_data`. The new codes appear on `col_code` after that clock edge, with column i in bits [6i+5:6i].
- R2: In the clock cycle where the strobe is sampled low after having been sampled high, `drive_en` is set. It reads 1 after that clock edge.
- R3: A strobe rise clears `drive_en` at the same clock edge that loads the latch.
- R4: Changes on `line_data` or `pol_in` while no strobe rise is detected leave every output unchanged.
- R5: Column i (0-based) is output number i+1. With captured polarity 0, columns with even i report bank 0 (upper) and columns with odd i report bank 1 (lower). With captured polarity 1 the assignment is swapped.
- R6: The segment index of each column equals bits [5:4] of its latched code, giving values 0 to 3.
- R7: The top flag of a column is 1 only when its latched code is 63 (all ones).
- R8: After reset the latch holds all zeros, the captured polarity is 0, and `drive_en` is 0.
- R9: A strobe held high for several cycles loads the latch once only. Data that changes during the high phase is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb | input | 1 | Line strobe, one pulse per line |
| pol_in | input | 1 | Polarity request, captured on strobe rise |
| line_data | input | NCOL*6 | Filled data register, 6 bits per column |
| col_code | output | NCOL*6 | Latched grey code per column |
| col_bank | output | NCOL | Bank select per column (0 upper, 1 lower) |
| col_seg | output | NCOL*2 | Segment index per column |
| col_top | output | NCOL | Exact-last-reference flag per column |
| drive_en | output | 1 | Output drive enable |

## Verification
Two functions share one clock edge: loading a new line and clearing the drive-enable. In addition, a new polarity takes effect at that same edge. The bench starts strobe pulses while `drive_en` is high, and in the same cycle it presents fresh data and a flipped polarity. It also changes data and polarity in the cycle just after a rise and throughout long strobe-high phases. A behavioural model is stepped every clock and compared at the falling edge. That comparison shows whether the new codes, the swapped banks and the dropped enable all appear together, and whether data arriving one cycle late is ignored.

// File: rtl/line_latch_pol.sv
module line_latch_pol #(
  parameter int NCOL = 8,
  parameter int CW   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strb,
  input  logic               pol_in,
  input  logic [NCOL*CW-1:0] line_data,
  output logic [NCOL*CW-1:0] col_code,
  output logic [NCOL-1:0]    col_bank,
  output logic [NCOL*2-1:0]  col_seg,
  output logic [NCOL-1:0]    col_top,
  output logic               drive_en
);
  localparam logic [CW-1:0] TOP_CODE = '1;

  logic               strb_q;
  logic               pol_q;
  logic [NCOL*CW-1:0] lat;

  wire rise = strb & ~strb_q;
  wire fall = ~strb & strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q   <= 1'b0;
      pol_q    <= 1'b0;
      lat      <= '0;
      drive_en <= 1'b0;
    end else begin
      strb_q <= strb;
      if (rise) begin
        lat      <= line_data;
        pol_q    <= pol_in;
        drive_en <= 1'b0;
      end else if (fall) begin
        drive_en <= 1'b1;
      end
    end
  end

  assign col_code = lat;

  for (genvar g = 0; g < NCOL; g++) begin : g_col
    localparam logic ODD_IDX = logic'(g % 2);
    wire [CW-1:0] c = lat[g*CW +: CW];
    assign col_bank[g]       = pol_q ^ ODD_IDX;
    assign col_seg[g*2 +: 2] = c[CW-1 -: 2];
    assign col_top[g]        = (c == TOP_CODE);
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && !strb_q) |=> (col_code == $past(line_data)));

  assert_en_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> ($past(strb_q) && !$past(strb)));

  assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && !strb_q) |=> !drive_en);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb && !strb_q) |=> ($stable(col_code) && $stable(col_bank)));

  assert_bank_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (NCOL < 2) || (col_bank[0] != col_bank[NCOL-1] ? (NCOL % 2 == 0) : (NCOL % 2 == 1)));
endmodule

// File: tb/line_latch_pol_tb.sv
`timescale 1ns/1ps
module line_latch_pol_tb;
  localparam int NCOL = 8;
  localparam int CW   = 6;

  logic clk = 1'b0, rst_n = 1'b0, strb = 1'b0, pol_in = 1'b0;
  logic [NCOL*CW-1:0] line_data = '0;
  logic [NCOL*CW-1:0] col_code;
  logic [NCOL-1:0]    col_bank, col_top;
  logic [NCOL*2-1:0]  col_seg;
  logic               drive_en;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_latch_pol #(.NCOL(NCOL), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pol_in(pol_in), .line_data(line_data),
    .col_code(col_code), .col_bank(col_bank), .col_seg(col_seg), .col_top(col_top),
    .drive_en(drive_en));

  int m_code[NCOL];
  int m_pol, m_en, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOL; i++) m_code[i] = 0;
      m_pol = 0; m_en = 0; m_prev = 0;
    end else begin
      if (strb && !m_prev) begin
        for (int i = 0; i < NCOL; i++) m_code[i] = int'(line_data[i*CW +: CW]);
        m_pol = int'(pol_in); m_en = 0;
      end else if (!strb && m_prev) m_en = 1;
      m_prev = int'(strb);
    end
  end

  task automatic chk(string tag, longint got, longint exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NCOL; i++) begin
        chk("R1 code", col_code[i*CW +: CW], m_code[i]);
        chk("R5 bank", col_bank[i], m_pol ^ (i % 2));
        chk("R6 seg", col_seg[i*2 +: 2], m_code[i] / 16);
        chk("R7 top", col_top[i], m_code[i] == 63);
      end
      chk("R2/R3 drive_en", drive_en, m_en);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_line();
    for (int i = 0; i < NCOL; i++) line_data[i*CW +: CW] = CW'($urandom_range(0, 63));
  endtask

  task automatic pulse(int width, logic p);
    @(negedge clk); strb = 1'b1; pol_in = p;
    repeat (width) @(negedge clk);
    strb = 1'b0;
  endtask

  logic [NCOL*CW-1:0] held;

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset drive_en", drive_en, 0);
    chk("R8 reset code", col_code, 0);
    chk("R8 reset bank", col_bank, 64'(8'b1010_1010));
    rst_n = 1'b1;
    idle(2);
    for (int i = 0; i < NCOL; i++) line_data[i*CW +: CW] = CW'(i * 9);
    line_data[0 +: CW] = 6'h3F; line_data[CW +: CW] = 6'h10;
    line_data[2*CW +: CW] = 6'h20; line_data[3*CW +: CW] = 6'h30;
    pulse(1, 1'b0); idle(4);
    chk("R2 enable after fall", drive_en, 1);
    chk("R7 top on 3F", col_top[0], 1);
    held = col_code;
    rand_line(); pol_in = 1'b1; idle(5);
    chk("R4 code held", col_code, held);
    chk("R4 bank held", col_bank, 64'(8'b1010_1010));
    rand_line();
    pulse(1, 1'b1);
    chk("R3 enable cleared", drive_en, 0);
    chk("R5 bank swapped", col_bank, 64'(8'b0101_0101));
    idle(3);
    held = col_code;
    @(negedge clk); rand_line(); strb = 1'b1; pol_in = 1'b0;
    @(negedge clk); held = col_code; rand_line(); pol_in = 1'b1;
    repeat (3) begin @(negedge clk); rand_line(); end
    chk("R9 single load", col_code, held);
    chk("R9 polarity kept", col_bank, 64'(8'b1010_1010));
    strb = 1'b0; idle(3);
    for (int k = 0; k < 150; k++) begin
      rand_line();
      if (k % 7 == 0) line_data[(k % NCOL)*CW +: CW] = 6'h3F;
      if (k % 5 == 0) line_data[((k+3) % NCOL)*CW +: CW] = 6'h00;
      pulse(1 + (k % 4), logic'($urandom_range(0, 1)));
      @(negedge clk); rand_line(); pol_in = ~pol_in;
      idle(k % 3);
    end
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_run++; done = 1;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule